// File: doc/BRIEF.md
# Phase Pulse Width One-Shot Timer

This block sets how long one output phase of a three-phase inverter stays active within each carrier period. A carrier timer elsewhere issues a single-cycle trigger at the start of each period. On that trigger the block takes a snapshot of its configuration and raises its pulse output. It then counts count-source ticks down to zero and drops the pulse. Three copies of the block, one each for the U, V and W phases, feed a separate dead-time and output stage.

Two modulation styles are supported. In sawtooth mode the pulse lasts for the primary width value, counted in ticks. In triangular mode the pulse covers two half-periods of the carrier. By default each half lasts the primary width, which gives twice the primary value in total. With the dual-register select set, the first half uses the primary width and the second half uses the secondary width, which gives asymmetric pulses. The width and mode inputs may change at any time. Only the values present at a trigger are used, and a trigger that arrives while a pulse is running restarts the one-shot from those values.

Top module: `phase_pw_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pulse` is 0.
- R2: In sawtooth mode (`tri_mode`=0), a trigger with `width_a`=k (1 to 65535) gives a pulse that stays 1 for exactly k tick cycles.
- R3: In triangular mode (`tri_mode`=1) with `dual_sel`=0, a trigger with `width_a`=k gives a pulse of exactly 2×k ticks.
- R4: In triangular mode with `dual_sel`=1, the pulse lasts `width_a` ticks for the first half and then `width_b` ticks for the second half, so the total is `width_a`+`width_b`. A zero half is skipped.
- R5: In sawtooth mode, `dual_sel` and `width_b` have no effect on the pulse width.
- R6: `pulse` rises in the cycle after the clock edge at which `trig` is sampled 1, provided the first loaded half is nonzero.
- R7: The count advances only on edges where `tick` is 1. With neither `tick` nor `trig` at an edge, `pulse` holds its value.
- R8: Changes to `width_a`, `width_b`, `tri_mode` and `dual_sel` made after a trigger do not alter the running pulse. They take effect at the next trigger.
- R9: A trigger during a running pulse takes priority over the count, including on the edge where the count would expire. It restarts the one-shot with the values present then, and `pulse` stays 1 throughout.
- R10: A trigger whose total width is zero (sawtooth with `width_a`=0, or triangular where both halves are zero) leaves `pulse` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-source enable, one count per cycle in which it is 1 |
| trig | input | 1 | Start (or restart) strobe from the carrier timer |
| tri_mode | input | 1 | 1 = triangular modulation, 0 = sawtooth |
| dual_sel | input | 1 | 1 = second half of a triangular pulse uses `width_b` |
| width_a | input | 16 | Primary width value in ticks |
| width_b | input | 16 | Secondary width value in ticks |
| pulse | output | 1 | Phase pulse to the output stage, 1 while active |

## Verification
Two events can land on the same edge: the trigger and the final tick that would end the count. The same applies to a trigger that coincides with any ordinary tick while a pulse is running. The bench sends a restart trigger on exactly the edge where a running count reaches its last tick, and another one part way through a pulse. For each case it predicts one unbroken pulse whose tick count is the ticks elapsed before the restart plus the new width. The monitor measures the pulse in ticks and compares the result against that prediction. An early drop at expiry, or a missing reload, changes the measured length.

// File: rtl/pw_pkg.sv
// Package pw_pkg
// Shared types for the phase pulse width timer. Holds the phase enum used by
// the sequencer and observed by the top module.
package pw_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } ph_e;
endpackage

// File: rtl/pw_shadow.sv
// Module pw_shadow
// Buffers the configuration inputs. A snapshot is taken on every trigger. The
// effective outputs show the live inputs during a trigger cycle (so the
// sequencer can load at once) and the stored snapshot at all other times.
// Assumes trig is a single-cycle strobe sampled on the rising clock edge.
module pw_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trig,
    input  logic         tri_in,
    input  logic         dual_in,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic         eff_tri,
    output logic         eff_dual,
    output logic [W-1:0] eff_a,
    output logic [W-1:0] eff_b
);
    logic         s_tri, s_dual;
    logic [W-1:0] s_a, s_b;

    // Purpose: capture the configuration snapshot on a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_tri  <= 1'b0;
            s_dual <= 1'b0;
            s_a    <= '0;
            s_b    <= '0;
        end else if (trig) begin
            s_tri  <= tri_in;
            s_dual <= dual_in;
            s_a    <= a_in;
            s_b    <= b_in;
        end
    end

    // Purpose: present the values that apply in this cycle.
    always_comb begin
        eff_tri  = trig ? tri_in  : s_tri;
        eff_dual = trig ? dual_in : s_dual;
        eff_a    = trig ? a_in    : s_a;
        eff_b    = trig ? b_in    : s_b;
    end
endmodule

// File: rtl/pw_counter.sv
// Module pw_counter
// Loadable down-counter in tick units. It flags expiry on the tick that
// consumes the last count. Assumes a load value of zero is never requested
// (the sequencer skips empty halves).
module pw_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt;

    // Purpose: load a new half-period length or count down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Purpose: mark the tick that ends the current half.
    always_comb begin
        expire = run && tick && (cnt == {{(W-1){1'b0}}, 1'b1});
    end
endmodule

// File: rtl/pw_seq.sv
// Module pw_seq
// Phase sequencer. A trigger (highest priority) loads the first half, or the
// second half directly when the first is empty. Expiry of the first half in
// triangular mode moves on to the second half. Any other expiry returns to
// idle. Assumes the eff_* inputs come from pw_shadow.
module pw_seq
    import pw_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trig,
    input  logic         expire,
    input  logic         eff_tri,
    input  logic         eff_dual,
    input  logic [W-1:0] eff_a,
    input  logic [W-1:0] eff_b,
    output logic         load,
    output logic [W-1:0] load_val,
    output ph_e          phase
);
    ph_e          ph_nxt;
    logic [W-1:0] half2;

    // Purpose: choose the second-half length.
    always_comb begin
        half2 = eff_dual ? eff_b : eff_a;
    end

    // Purpose: next-phase and load decision.
    always_comb begin
        ph_nxt   = phase;
        load     = 1'b0;
        load_val = eff_a;
        if (trig) begin
            if (eff_a != '0) begin
                ph_nxt = PH_FIRST;
                load   = 1'b1;
            end else if (eff_tri && half2 != '0) begin
                ph_nxt   = PH_SECOND;
                load     = 1'b1;
                load_val = half2;
            end else begin
                ph_nxt = PH_IDLE;
            end
        end else if (expire) begin
            if (phase == PH_FIRST && eff_tri && half2 != '0) begin
                ph_nxt   = PH_SECOND;
                load     = 1'b1;
                load_val = half2;
            end else begin
                ph_nxt = PH_IDLE;
            end
        end
    end

    // Purpose: phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= ph_nxt;
    end
endmodule

// File: rtl/phase_pw_timer.sv
// Module phase_pw_timer (top)
// One-shot pulse width timer for a single inverter phase. The pulse is 1
// whenever the sequencer is in a half-period. Assumes tick and trig are
// synchronous to clk.
module phase_pw_timer
    import pw_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         trig,
    input  logic         tri_mode,
    input  logic         dual_sel,
    input  logic [W-1:0] width_a,
    input  logic [W-1:0] width_b,
    output logic         pulse
);
    logic         eff_tri, eff_dual, load, expire;
    logic [W-1:0] eff_a, eff_b, load_val;
    ph_e          phase;

    pw_shadow #(.W(W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .trig(trig),
        .tri_in(tri_mode), .dual_in(dual_sel), .a_in(width_a), .b_in(width_b),
        .eff_tri(eff_tri), .eff_dual(eff_dual), .eff_a(eff_a), .eff_b(eff_b)
    );

    pw_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .run(phase != PH_IDLE), .tick(tick), .expire(expire)
    );

    pw_seq #(.W(W)) u_seq (
        .clk(clk), .rst_n(rst_n), .trig(trig), .expire(expire),
        .eff_tri(eff_tri), .eff_dual(eff_dual), .eff_a(eff_a), .eff_b(eff_b),
        .load(load), .load_val(load_val), .phase(phase)
    );

    // Purpose: drive the phase pulse from the sequencer state.
    always_comb begin
        pulse = (phase != PH_IDLE);
    end
endmodule

// File: rtl/pw_chk.sv
// Module pw_chk
// Temporal checks on the ports of phase_pw_timer, attached by bind.
module pw_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         trig,
    input logic         tri_mode,
    input logic [W-1:0] width_a,
    input logic         pulse
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !pulse);

    assert_rise_after_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(trig));

    assert_trig_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && width_a != '0) |=> pulse);

    assert_hold_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !tick) |=> $stable(pulse));

    assert_fall_on_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse) |-> ($past(tick) || $past(trig)));

    assert_zero_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !tri_mode && width_a == '0) |=> !pulse);
endmodule

bind phase_pw_timer pw_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig),
    .tri_mode(tri_mode), .width_a(width_a), .pulse(pulse)
);

// File: tb/phase_pw_timer_tb.sv
module phase_pw_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        trig = 1'b0;
    logic        tri_mode = 1'b0;
    logic        dual_sel = 1'b0;
    logic [15:0] width_a = '0;
    logic [15:0] width_b = '0;
    logic        pulse;

    int    errors = 0;
    int    checks = 0;
    int    tick_div = 1;
    int    tick_ph = 0;
    bit    finished = 0;
    int    exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    phase_pw_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig),
        .tri_mode(tri_mode), .dual_sel(dual_sel),
        .width_a(width_a), .width_b(width_b), .pulse(pulse)
    );

    // tick generator: one tick every tick_div cycles
    initial forever begin
        @(posedge clk); #2;
        tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
        tick = (tick_ph == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: measures each pulse in ticks and compares with the scoreboard
    int  meas = 0;
    bit  inp = 0;
    always @(negedge clk) begin
        if (pulse) begin
            inp = 1;
            if (tick) meas++;
        end else if (inp) begin
            inp = 0;
            if (exp_q.size() == 0) begin
                check(0, "unexpected pulse", meas, 0);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(meas == e, t, meas, e);
            end
            meas = 0;
        end
    end

    // called at posedge+2; trig sampled at the next edge
    task automatic fire();
        trig = 1'b1;
        @(posedge clk); #2;
        trig = 1'b0;
    endtask

    task automatic setup(input logic [15:0] a, input logic [15:0] b, input bit tm, input bit ds);
        width_a = a; width_b = b; tri_mode = tm; dual_sel = ds;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic run_pulse(input logic [15:0] a, input logic [15:0] b, input bit tm,
                             input bit ds, input int e, input string t);
        setup(a, b, tm, ds);
        exp_q.push_back(e); tag_q.push_back(t);
        fire();
        idle(e * tick_div + 6);
    endtask

    task automatic expect_none(input string t);
        fire();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(pulse == 1'b0, t, pulse, 0);
        end
        @(posedge clk); #2;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pulse == 1'b0, "R1 reset", pulse, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        check(pulse == 1'b0, "R1 after reset", pulse, 0);
        @(posedge clk); #2;

        // R6: timing of the rise
        setup(16'd4, 16'd0, 1'b0, 1'b0);
        exp_q.push_back(4); tag_q.push_back("R6 width");
        @(negedge clk);
        check(pulse == 1'b0, "R6 before trig", pulse, 0);
        @(posedge clk); #2;
        fire();
        @(negedge clk);
        check(pulse == 1'b1, "R6 rise", pulse, 1);
        idle(10);

        run_pulse(16'd5,  16'd0, 1'b0, 1'b0, 5,  "R2 saw 5");
        run_pulse(16'd1,  16'd0, 1'b0, 1'b0, 1,  "R2 saw 1");
        run_pulse(16'd3,  16'd0, 1'b1, 1'b0, 6,  "R3 tri 3");
        run_pulse(16'd7,  16'd2, 1'b1, 1'b0, 14, "R3 tri ignores b");
        run_pulse(16'd3,  16'd5, 1'b1, 1'b1, 8,  "R4 dual 3+5");
        run_pulse(16'd0,  16'd4, 1'b1, 1'b1, 4,  "R4 dual 0+4");
        run_pulse(16'd6,  16'd0, 1'b1, 1'b1, 6,  "R4 dual 6+0");
        run_pulse(16'd4,  16'd9, 1'b0, 1'b1, 4,  "R5 saw ignores dual");

        // R7: sparse ticks
        tick_div = 3;
        run_pulse(16'd4,  16'd0, 1'b0, 1'b0, 4,  "R7 sparse saw");
        run_pulse(16'd2,  16'd3, 1'b1, 1'b1, 5,  "R7 sparse dual");
        tick_div = 1;
        idle(4);

        // R8: buffered writes
        setup(16'd5, 16'd0, 1'b0, 1'b0);
        exp_q.push_back(5); tag_q.push_back("R8 change ignored");
        fire();
        idle(1);
        setup(16'd20, 16'd7, 1'b1, 1'b1);
        idle(12);
        exp_q.push_back(27); tag_q.push_back("R8 applied at next trig");
        fire();
        idle(34);

        // R9: restart part way (j=2) and at the expiry edge (j=3)
        setup(16'd5, 16'd0, 1'b0, 1'b0);
        exp_q.push_back(2 + 6); tag_q.push_back("R9 mid restart");
        fire();
        idle(1);
        setup(16'd6, 16'd0, 1'b0, 1'b0);
        fire();
        idle(12);

        setup(16'd3, 16'd0, 1'b0, 1'b0);
        exp_q.push_back(3 + 4); tag_q.push_back("R9 restart on expiry");
        fire();
        idle(2);
        setup(16'd4, 16'd0, 1'b0, 1'b0);
        fire();
        idle(10);

        // R10: zero widths
        setup(16'd0, 16'd9, 1'b0, 1'b1);
        expect_none("R10 saw zero");
        setup(16'd0, 16'd0, 1'b1, 1'b1);
        expect_none("R10 tri zero");
        setup(16'd0, 16'd5, 1'b1, 1'b0);
        expect_none("R10 tri single zero");

        idle(4);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule